// File: doc/BRIEF.md
# Paired Peripheral DMA Channel Controller

This block moves single data items between one serial peripheral and system memory, so the processor does not have to. It holds two channels. The receive channel takes the word in the peripheral's receive holding register and writes it to memory. The transmit channel reads a word from memory and hands it to the peripheral's transmit holding register. The peripheral starts each item with a one-cycle request strobe. The memory side is a single-beat request/grant port.

Each channel keeps a current pointer and item count, plus a second pointer/count pair that is waiting in line. When the current count runs out, the waiting pair takes its place in the same cycle, so chained buffers follow each other without a gap. Software programs the registers through a word-indexed write/read port. Software also sees per-direction flags for end of buffer and for both buffers empty.

A three-state arbiter owns the memory port:
- **ARB_IDLE** goes to **ARB_RX** when receive has a pending item (transition *pick_rx*). Otherwise it goes to **ARB_TX** when transmit has one (*pick_tx*).
- **ARB_RX** and **ARB_TX** present the access. They return to ARB_IDLE on grant (*served*). They also return to ARB_IDLE when their channel stops being live, that is disabled or at count zero (*withdrawn*).

Top module: `pdma_pair_ctrl`

## Requirements
- R1: After reset every pointer and count is zero, both channels are disabled, all four end/full flags are high and no memory request is made.
- R2: Register word indices:
  - 0 to 3 are the receive current pointer, current count, next pointer and next count.
  - 4 to 7 are the same four registers for transmit.
  - Index 8 is the write-only control word: bit0 enables receive, bit1 disables it, bit2 enables transmit, bit3 disables it.
  - Index 9 reads the status word: bit0 is receive enabled, bit1 is transmit enabled.
  - Index 10 is the item-size word: bits 1:0 for receive, bits 3:2 for transmit, where code 0 means 1 byte, 1 means 2 bytes and 2 or 3 mean 4 bytes.
- R3: Each served receive request performs one memory write of `rx_data` at the receive current pointer. The pointer then advances by the item size and the count drops by one.
- R4: Each served transmit request performs one memory read at the transmit current pointer. In the cycle after the grant, `tx_load` pulses for one cycle with the read word on `tx_data`.
- R5: When a served item would take the current count to zero while the next count is nonzero, the next pointer and next count become current in that cycle and the next count becomes zero.
- R6: The end flag of a direction is high exactly when its current count is zero. The full flag is high when both its current and next counts are zero. Writing a nonzero count clears the matching flag.
- R7: A channel whose current count is zero ignores request strobes.
- R8: Up to 2^PEND_W-1 request strobes per channel are held while an access is outstanding, and each is served in turn.
- R9: A disabled channel ignores strobes and drops its held requests. Disable wins over enable in the same write.
- R10: When both channels have held requests while the arbiter is idle, the receive access is issued first.
- R11: Writing zero to a current count stops that channel at once: an access not yet granted is withdrawn and its held requests are dropped.
- R12: Once raised, a memory request keeps its address and direction until granted, unless a register write intervenes. Each grant is followed by at least one cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| rx_req | input | 1 | Peripheral receive-ready strobe |
| rx_data | input | DW | Peripheral receive holding register |
| tx_req | input | 1 | Peripheral transmit-ready strobe |
| tx_load | output | 1 | Load pulse for the transmit holding register |
| tx_data | output | DW | Word for the transmit holding register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory grant, completes the access this cycle |
| mem_rdata | input | DW | Memory read data, valid with the grant |
| rx_end | output | 1 | Receive current count is zero |
| rx_full | output | 1 | Receive current and next counts are zero |
| tx_end | output | 1 | Transmit current count is zero |
| tx_full | output | 1 | Transmit current and next counts are zero |

## Verification
The bench builds the block with its defaults: AW=32, DW=32, CW=16 and PEND_W=2. The three-deep request hold can therefore be filled with three closely spaced strobes while a slow memory delays the grant. The bench varies grant latency from one to twenty cycles, which makes room to withdraw an access by a zero count write before it is granted. Small counts let chained reloads, the exhausted state and the rule that receive goes before transmit each be reached within a few items.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int unsigned RW = 32;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_RX,
        ARB_TX
    } arb_state_e;

    localparam logic [3:0] IDX_CTRL = 4'd8;
    localparam logic [3:0] IDX_STAT = 4'd9;
    localparam logic [3:0] IDX_SIZE = 4'd10;

    function automatic logic [2:0] item_bytes(input logic [1:0] code);
        logic [2:0] b;
        case (code)
            2'd0:    b = 3'd1;
            2'd1:    b = 3'd2;
            default: b = 3'd4;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int          AW     = 32,
    parameter int          CW     = 16,
    parameter int          PEND_W = 2,
    parameter logic [3:0]  BASE   = 4'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_idx,
    input  logic [RW-1:0]   reg_wdata,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic [1:0]      size_code,
    input  logic            req,
    input  logic            done,
    output logic            en,
    output logic [AW-1:0]   ptr,
    output logic [CW-1:0]   cnt,
    output logic [AW-1:0]   nptr,
    output logic [CW-1:0]   ncnt,
    output logic            live,
    output logic            want
);

    localparam logic [3:0]        I_PTR    = BASE;
    localparam logic [3:0]        I_CNT    = BASE + 4'd1;
    localparam logic [3:0]        I_NPTR   = BASE + 4'd2;
    localparam logic [3:0]        I_NCNT   = BASE + 4'd3;
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [AW-1:0]     ptr_q, ptr_d, nptr_q, nptr_d;
    logic [CW-1:0]     cnt_q, cnt_d, ncnt_q, ncnt_d;
    logic              en_q, en_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic              take, serve;

    assign live  = en_q && (cnt_q != '0);
    assign want  = live && (pend_q != '0);
    assign serve = done && live;
    assign take  = req && live && ((pend_q != PEND_MAX) || serve);

    always_comb begin
        ptr_d  = ptr_q;
        cnt_d  = cnt_q;
        nptr_d = nptr_q;
        ncnt_d = ncnt_q;
        en_d   = en_q;
        pend_d = pend_q;

        // advance or chain to the waiting buffer
        if (serve) begin
            if ((cnt_q == CW'(1)) && (ncnt_q != '0)) begin
                ptr_d  = nptr_q;
                cnt_d  = ncnt_q;
                ncnt_d = '0;
            end else begin
                ptr_d = ptr_q + AW'(item_bytes(size_code));
                cnt_d = cnt_q - CW'(1);
            end
        end

        // software writes override the datapath
        if (reg_we) begin
            if (reg_idx == I_PTR)  ptr_d  = reg_wdata[AW-1:0];
            if (reg_idx == I_CNT)  cnt_d  = reg_wdata[CW-1:0];
            if (reg_idx == I_NPTR) nptr_d = reg_wdata[AW-1:0];
            if (reg_idx == I_NCNT) ncnt_d = reg_wdata[CW-1:0];
        end

        if (en_clr)      en_d = 1'b0;
        else if (en_set) en_d = 1'b1;

        case ({take, serve})
            2'b10:   pend_d = pend_q + PEND_W'(1);
            2'b01:   pend_d = pend_q - PEND_W'(1);
            default: pend_d = pend_q;
        endcase
        if (!en_d || (cnt_d == '0)) pend_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cnt_q  <= '0;
            nptr_q <= '0;
            ncnt_q <= '0;
            en_q   <= 1'b0;
            pend_q <= '0;
        end else begin
            ptr_q  <= ptr_d;
            cnt_q  <= cnt_d;
            nptr_q <= nptr_d;
            ncnt_q <= ncnt_d;
            en_q   <= en_d;
            pend_q <= pend_d;
        end
    end

    assign en   = en_q;
    assign ptr  = ptr_q;
    assign cnt  = cnt_q;
    assign nptr = nptr_q;
    assign ncnt = ncnt_q;

endmodule

// File: rtl/pdma_arb.sv
module pdma_arb
    import pdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_want,
    input  logic       tx_want,
    input  logic       rx_live,
    input  logic       tx_live,
    input  logic       mem_gnt,
    output logic       mem_req,
    output logic       mem_we,
    output logic       rx_done,
    output logic       tx_done,
    output logic       sel_tx
);

    arb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (rx_want)      state_d = ARB_RX;   // pick_rx
                else if (tx_want) state_d = ARB_TX;   // pick_tx
            end
            ARB_RX: begin
                if (!rx_live || mem_gnt) state_d = ARB_IDLE;  // withdrawn / served
            end
            ARB_TX: begin
                if (!tx_live || mem_gnt) state_d = ARB_IDLE;  // withdrawn / served
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        rx_done = 1'b0;
        tx_done = 1'b0;
        sel_tx  = 1'b0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_RX: begin
                mem_req = rx_live;
                mem_we  = 1'b1;
                rx_done = rx_live && mem_gnt;
            end
            ARB_TX: begin
                mem_req = tx_live;
                sel_tx  = 1'b1;
                tx_done = tx_live && mem_gnt;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pdma_pair_ctrl.sv
module pdma_pair_ctrl
    import pdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CW     = 16,
    parameter int PEND_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_idx,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            rx_req,
    input  logic [DW-1:0]   rx_data,
    input  logic            tx_req,
    output logic            tx_load,
    output logic [DW-1:0]   tx_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_gnt,
    input  logic [DW-1:0]   mem_rdata,
    output logic            rx_end,
    output logic            rx_full,
    output logic            tx_end,
    output logic            tx_full
);

    localparam int NCH = 2;

    logic [AW-1:0] ch_ptr  [NCH];
    logic [AW-1:0] ch_nptr [NCH];
    logic [CW-1:0] ch_cnt  [NCH];
    logic [CW-1:0] ch_ncnt [NCH];
    logic [NCH-1:0] ch_en, ch_live, ch_want, ch_done, ch_req;
    logic [NCH-1:0] en_set, en_clr;
    logic [1:0]     size_q [NCH];
    logic           rx_want, tx_want, rx_live, tx_live, sel_tx;
    logic           tx_load_q;
    logic [DW-1:0]  tx_data_q;
    logic           ctrl_wr, size_wr;

    assign ctrl_wr = reg_we && (reg_idx == IDX_CTRL);
    assign size_wr = reg_we && (reg_idx == IDX_SIZE);
    assign ch_req  = {tx_req, rx_req};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign en_set[g] = ctrl_wr && reg_wdata[2*g];
        assign en_clr[g] = ctrl_wr && reg_wdata[2*g+1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       size_q[g] <= 2'd0;
            else if (size_wr) size_q[g] <= reg_wdata[2*g+1 -: 2];
        end

        pdma_chan #(
            .AW(AW), .CW(CW), .PEND_W(PEND_W), .BASE(4'(4*g))
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
            .en_set(en_set[g]), .en_clr(en_clr[g]), .size_code(size_q[g]),
            .req(ch_req[g]), .done(ch_done[g]),
            .en(ch_en[g]), .ptr(ch_ptr[g]), .cnt(ch_cnt[g]),
            .nptr(ch_nptr[g]), .ncnt(ch_ncnt[g]),
            .live(ch_live[g]), .want(ch_want[g])
        );
    end

    assign rx_want = ch_want[0];
    assign tx_want = ch_want[1];
    assign rx_live = ch_live[0];
    assign tx_live = ch_live[1];

    pdma_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .rx_want(rx_want), .tx_want(tx_want),
        .rx_live(rx_live), .tx_live(tx_live),
        .mem_gnt(mem_gnt),
        .mem_req(mem_req), .mem_we(mem_we),
        .rx_done(ch_done[0]), .tx_done(ch_done[1]),
        .sel_tx(sel_tx)
    );

    assign mem_addr  = sel_tx ? ch_ptr[1] : ch_ptr[0];
    assign mem_wdata = rx_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load_q <= 1'b0;
            tx_data_q <= '0;
        end else begin
            tx_load_q <= ch_done[1];
            if (ch_done[1]) tx_data_q <= mem_rdata;
        end
    end

    assign tx_load = tx_load_q;
    assign tx_data = tx_data_q;

    always_comb begin
        reg_rdata = '0;
        if (!reg_idx[3]) begin
            case (reg_idx[1:0])
                2'd0:    reg_rdata = RW'(ch_ptr[reg_idx[2]]);
                2'd1:    reg_rdata = RW'(ch_cnt[reg_idx[2]]);
                2'd2:    reg_rdata = RW'(ch_nptr[reg_idx[2]]);
                default: reg_rdata = RW'(ch_ncnt[reg_idx[2]]);
            endcase
        end else if (reg_idx == IDX_STAT) begin
            reg_rdata = RW'(ch_en);
        end else if (reg_idx == IDX_SIZE) begin
            reg_rdata = RW'({size_q[1], size_q[0]});
        end
    end

    assign rx_end  = (ch_cnt[0] == '0);
    assign rx_full = rx_end && (ch_ncnt[0] == '0);
    assign tx_end  = (ch_cnt[1] == '0);
    assign tx_full = tx_end && (ch_ncnt[1] == '0);

endmodule

// File: rtl/pdma_pair_chk.sv
module pdma_pair_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [3:0]    reg_idx,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt,
    input logic          tx_load,
    input logic          rx_end,
    input logic          rx_full,
    input logic          tx_end,
    input logic          tx_full,
    input logic          rx_want
);

    p_rx_full_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_end);

    p_tx_full_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> tx_end);

    p_tx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(mem_req && mem_gnt && !mem_we));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !reg_we) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    p_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !reg_we) |=> !(mem_req && mem_we));

    p_zero_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_idx == 4'd1) && (reg_wdata == 32'd0)) |=> !(mem_req && mem_we));

    p_rx_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && $past(rx_want) && !$past(reg_we)) |-> mem_we);

endmodule

bind pdma_pair_ctrl pdma_pair_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .tx_load(tx_load),
    .rx_end(rx_end), .rx_full(rx_full), .tx_end(tx_end), .tx_full(tx_full),
    .rx_want(rx_want)
);

// File: tb/test_pdma_pair_ctrl.sv
module test_pdma_pair_ctrl;

    localparam logic [31:0] RD_MASK = 32'h5A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_req = 1'b0;
    logic [31:0] rx_data = '0;
    logic        tx_req = 1'b0;
    logic        tx_load;
    logic [31:0] tx_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata;
    logic        rx_end, rx_full, tx_end, tx_full;

    int n_chk = 0;
    int n_err = 0;
    int lat = 1;
    int wcnt = 0;
    logic [31:0] held_addr;
    bit done_flag = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } xact_t;

    xact_t       exp_q[$];
    logic [31:0] exp_tx_q[$];

    always #5 clk = ~clk;

    assign mem_rdata = mem_addr ^ RD_MASK;

    pdma_pair_ctrl i_pdma_pair_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_req(rx_req), .rx_data(rx_data), .tx_req(tx_req),
        .tx_load(tx_load), .tx_data(tx_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .rx_end(rx_end), .rx_full(rx_full), .tx_end(tx_end), .tx_full(tx_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        xact_t x;
        x.we = 1'b1; x.addr = a; x.data = d; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic push_rd(input logic [31:0] a, input string tag);
        xact_t x;
        x.we = 1'b0; x.addr = a; x.data = '0; x.tag = tag;
        exp_q.push_back(x);
        exp_tx_q.push_back(a ^ RD_MASK);
    endtask

    task automatic pulse_rx(input logic [31:0] d);
        @(negedge clk);
        rx_req = 1'b1; rx_data = d;
        @(negedge clk);
        rx_req = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 300; i++) begin
            if (exp_q.size() == 0 && exp_tx_q.size() == 0) break;
            @(negedge clk);
        end
        chk({tag, " pending expectations"}, 32'(exp_q.size() + exp_tx_q.size()), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    // memory model and scoreboard monitor for accesses
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_gnt = 1'b0;
            wcnt = 0;
        end else if (mem_gnt) begin
            mem_gnt = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt > 0) chk("R12 address held", mem_addr, held_addr);
            held_addr = mem_addr;
            if (wcnt >= lat) begin
                mem_gnt = 1'b1;
                wcnt = 0;
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R7 R9 R11 unexpected access actual=%h expected=none", mem_addr);
                end else begin
                    xact_t x;
                    x = exp_q.pop_front();
                    chk({x.tag, " direction"}, 32'(mem_we), 32'(x.we));
                    chk({x.tag, " address"}, mem_addr, x.addr);
                    if (x.we) chk({x.tag, " write data"}, mem_wdata, x.data);
                end
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    // monitor for the transmit holding-register load
    always @(negedge clk) begin
        if (rst_n && tx_load) begin
            if (exp_tx_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R4 unexpected tx_load actual=%h expected=none", tx_data);
            end else begin
                chk("R4 tx_data", tx_data, exp_tx_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd9, v); chk("R1 status", v, 32'd0);
        rd(4'd0, v); chk("R1 rx ptr", v, 32'd0);
        rd(4'd5, v); chk("R1 tx count", v, 32'd0);
        chk("R1 flags", {28'd0, rx_end, rx_full, tx_end, tx_full}, 32'hF);
        chk("R1 mem_req", 32'(mem_req), 32'd0);

        // R3 receive with 4-byte items, R2 map
        wr(4'd10, 32'h2);
        wr(4'd0, 32'h100);
        wr(4'd1, 32'd3);
        chk("R6 end cleared by count write", {30'd0, rx_end, rx_full}, 32'd0);
        wr(4'd8, 32'h1);
        rd(4'd9, v); chk("R9 status rx on", v, 32'd1);
        push_wr(32'h100, 32'hA1, "R3");
        pulse_rx(32'hA1); drain("R3");
        push_wr(32'h104, 32'hA2, "R3");
        pulse_rx(32'hA2); drain("R3");
        push_wr(32'h108, 32'hA3, "R3");
        pulse_rx(32'hA3); drain("R3");
        rd(4'd0, v); chk("R3 pointer advanced", v, 32'h10C);
        rd(4'd1, v); chk("R3 count", v, 32'd0);
        chk("R6 end and full", {30'd0, rx_end, rx_full}, 32'h3);

        // R7 ignored at count zero
        pulse_rx(32'hBB);
        repeat (10) @(negedge clk);
        rd(4'd0, v); chk("R7 pointer unchanged", v, 32'h10C);

        // R5 chained buffers with 2-byte items
        wr(4'd10, 32'h1);
        wr(4'd0, 32'h200);
        wr(4'd1, 32'd2);
        wr(4'd2, 32'h300);
        wr(4'd3, 32'd2);
        push_wr(32'h200, 32'hC1, "R5"); pulse_rx(32'hC1); drain("R5");
        push_wr(32'h202, 32'hC2, "R5"); pulse_rx(32'hC2); drain("R5");
        rd(4'd3, v); chk("R5 next count cleared", v, 32'd0);
        rd(4'd0, v); chk("R5 pointer reloaded", v, 32'h300);
        rd(4'd1, v); chk("R5 count reloaded", v, 32'd2);
        chk("R6 end low after reload", 32'(rx_end), 32'd0);
        push_wr(32'h300, 32'hC3, "R5"); pulse_rx(32'hC3); drain("R5");
        push_wr(32'h302, 32'hC4, "R5"); pulse_rx(32'hC4); drain("R5");
        chk("R6 end and full after chain", {30'd0, rx_end, rx_full}, 32'h3);

        // R4 transmit with 1-byte items
        wr(4'd10, 32'h1);
        wr(4'd4, 32'h400);
        wr(4'd5, 32'd2);
        wr(4'd8, 32'h4);
        rd(4'd9, v); chk("R9 status both on", v, 32'd3);
        push_rd(32'h400, "R4"); pulse_tx(); drain("R4");
        push_rd(32'h401, "R4"); pulse_tx(); drain("R4");
        chk("R6 tx end", 32'(tx_end), 32'd1);

        // R10 receive before transmit
        wr(4'd10, 32'h2);
        wr(4'd0, 32'h500); wr(4'd1, 32'd1);
        wr(4'd4, 32'h600); wr(4'd5, 32'd1);
        push_wr(32'h500, 32'hD1, "R10");
        push_rd(32'h600, "R10");
        @(negedge clk);
        rx_req = 1'b1; rx_data = 32'hD1; tx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0; tx_req = 1'b0;
        drain("R10");

        // R8 held requests under slow memory
        lat = 6;
        wr(4'd0, 32'h700); wr(4'd1, 32'd3);
        push_wr(32'h700, 32'hE0, "R8");
        push_wr(32'h704, 32'hE0, "R8");
        push_wr(32'h708, 32'hE0, "R8");
        pulse_rx(32'hE0); pulse_rx(32'hE0); pulse_rx(32'hE0);
        drain("R8");
        rd(4'd0, v); chk("R8 pointer after three", v, 32'h70C);

        // R11 zero count withdraws an ungranted access
        lat = 20;
        wr(4'd0, 32'h800); wr(4'd1, 32'd4);
        pulse_rx(32'hF1);
        repeat (3) @(negedge clk);
        wr(4'd1, 32'd0);
        chk("R11 request withdrawn", 32'(mem_req), 32'd0);
        repeat (30) @(negedge clk);
        rd(4'd0, v); chk("R11 pointer unchanged", v, 32'h800);
        chk("R11 end flag", 32'(rx_end), 32'd1);
        lat = 1;

        // R6 full clears on next count write
        wr(4'd3, 32'd1);
        chk("R6 full cleared, end kept", {30'd0, rx_end, rx_full}, 32'h2);

        // R9 disabled channel ignores and drops strobes
        wr(4'd8, 32'h3);
        rd(4'd9, v); chk("R9 disable wins", v, 32'd2);
        wr(4'd10, 32'h1);
        wr(4'd0, 32'h900); wr(4'd1, 32'd1);
        pulse_rx(32'h91);
        repeat (8) @(negedge clk);
        wr(4'd8, 32'h1);
        repeat (8) @(negedge clk);
        rd(4'd0, v); chk("R9 nothing moved", v, 32'h900);
        push_wr(32'h900, 32'h92, "R9"); pulse_rx(32'h92); drain("R9");
        rd(4'd0, v); chk("R5 reload after exhaust", v, 32'h300);
        rd(4'd1, v); chk("R5 reloaded count", v, 32'd1);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule